// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block shapes one programmed-I/O access to a parallel ATA task file. It runs from a 33 MHz timing clock, so each count below is one clock of roughly 30 ns. A one-cycle start request carries a direction, a channel and a device. The block then runs three phases. In the setup phase the address is valid and the strobe is idle. In the active phase the strobe for the chosen direction is driven low. In the recovery phase the strobe is idle again. After recovery the block raises a one-cycle done pulse.

Each of the four channel/device slots has a timing byte: bits 7:4 are the active count and bits 3:0 the recovery count, both in a wrapped code. Address setup uses a 2-bit field held in bits 7:6 of a setup register. Channel 0 has one setup register per device, and both devices on channel 1 share a single one. A simple write port loads these registers.

The block latches the timing of the selected slot when it accepts a start, so a register write during a cycle only affects later cycles. On reads it captures the device data on the last active clock. On writes it drives the write data from the first setup clock to the last active clock.

Top module: `ata_pio_strobe_gen`

## Requirements
- R1: While reset is asserted and just after it, busy, addr_valid, done and dd_oe are 0 and both rd_stb_n and wr_stb_n are 1.
- R2: Setup length comes from bits 7:6 of the setup register, with the code 01 = 2 clocks, 10 = 3, 00 = 4 and 11 = 5. For channel 0, device 0 uses address 4 and device 1 uses address 5. Bits 5:0 of a setup write have no effect.
- R3: The active length comes from bits 7:4 of the timing byte at address {chan,dev} (0 to 3). A value of 0 gives 16 clocks and values 1 to 15 give that many clocks.
- R4: The recovery length comes from bits 3:0 of the same byte. A value of 0 gives 16 clocks, values 1 to 14 give the value plus one, and 15 gives 1 clock.
- R5: addr_valid is high through setup, active and recovery. The strobe for the request is low only during active: wr_stb_n when start_rw=1, rd_stb_n when start_rw=0. The other strobe stays high.
- R6: done is high for exactly one cycle, the cycle after the last recovery clock. busy is high from the cycle after the accepted start through the last recovery clock, and low while done is high.
- R7: On a read, rdata takes dd_in as it stands on the last active clock. rdata keeps that value through later write cycles.
- R8: On a write, dd_out holds the wdata present at the accepted start and dd_oe is high through setup and active. dd_oe is low in recovery, when idle and during reads.
- R9: A start raised while busy is high is ignored. The running cycle keeps its direction and lengths, and no new cycle follows it.
- R10: A timing byte written during a cycle does not change that cycle. It applies from the next accepted start.
- R11: Both devices on channel 1 take their setup length from the shared register at address 6. Writes to addresses 4 and 5 do not change their setup length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock (33 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address: 0-3 timing bytes, 4-6 setup registers |
| cfg_wdata | input | 8 | Register write data |
| start | input | 1 | One-cycle request to begin an access |
| start_rw | input | 1 | 1 = write, 0 = read |
| start_chan | input | 1 | Channel select |
| start_dev | input | 1 | Device select within the channel |
| wdata | input | 16 | Write data, sampled with start |
| dd_in | input | 16 | Data bus from the device |
| busy | output | 1 | Access in progress |
| addr_valid | output | 1 | Address phase marker |
| rd_stb_n | output | 1 | Active-low read strobe |
| wr_stb_n | output | 1 | Active-low write strobe |
| dd_out | output | 16 | Data bus towards the device |
| dd_oe | output | 1 | Output enable for dd_out |
| rdata | output | 16 | Captured read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
An accepted start at clock edge k places setup in the S cycles after k. Active follows for A cycles and recovery for R cycles. done appears in cycle k+S+A+R+1, and rdata is valid from the first recovery cycle. The bench samples every output at the falling edge, one sample per cycle, and classifies each cycle by phase. It compares the run lengths of each phase with S, A and R decoded from its own copy of the registers, and checks the done and rdata values at the done sample. One more sample after done confirms that no ignored request started a cycle.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } pio_phase_e;

  localparam int LEN_W = 5;

  // active nibble: zero wraps to the maximum
  function automatic logic [LEN_W-1:0] act_clocks(input logic [3:0] nib);
    return (nib == 4'd0) ? LEN_W'(16) : {1'b0, nib};
  endfunction

  // recovery nibble: zero is the maximum, all ones is the minimum
  function automatic logic [LEN_W-1:0] rec_clocks(input logic [3:0] nib);
    logic [LEN_W-1:0] r;
    if (nib == 4'd0)       r = LEN_W'(16);
    else if (nib == 4'hF)  r = LEN_W'(1);
    else                   r = {1'b0, nib} + LEN_W'(1);
    return r;
  endfunction

  function automatic logic [LEN_W-1:0] setup_clocks(input logic [1:0] code);
    logic [LEN_W-1:0] r;
    unique case (code)
      2'b01:   r = LEN_W'(2);
      2'b10:   r = LEN_W'(3);
      2'b00:   r = LEN_W'(4);
      default: r = LEN_W'(5);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ata_pio_timing_regs.sv
module ata_pio_timing_regs #(
  parameter int CHAN_W = 1,
  parameter int DEV_W  = 1,
  parameter int CFG_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic [CHAN_W-1:0] sel_chan,
  input  logic [DEV_W-1:0]  sel_dev,
  output logic [7:0]        sel_timing,
  output logic [1:0]        sel_setup
);
  localparam int NCHAN  = 1 << CHAN_W;
  localparam int NDEV   = 1 << DEV_W;
  localparam int NSLOT  = NCHAN * NDEV;
  localparam int NSETUP = NDEV + NCHAN - 1;
  localparam int SUW    = (NSETUP > 1) ? $clog2(NSETUP) : 1;

  logic [7:0] tim_q   [NSLOT];
  logic [1:0] setup_q [NSETUP];
  logic [SUW-1:0] sidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++)  tim_q[i]   <= 8'h00;
      for (int j = 0; j < NSETUP; j++) setup_q[j] <= 2'b11;
    end else if (cfg_we) begin
      for (int i = 0; i < NSLOT; i++)
        if (cfg_addr == CFG_AW'(i)) tim_q[i] <= cfg_wdata;
      for (int j = 0; j < NSETUP; j++)
        if (cfg_addr == CFG_AW'(NSLOT + j)) setup_q[j] <= cfg_wdata[7:6];
    end
  end

  // channel 0 devices own a setup register each, later channels share one
  always_comb begin
    if (sel_chan == '0) sidx = SUW'(sel_dev);
    else                sidx = SUW'(NDEV + int'(sel_chan) - 1);
  end

  assign sel_timing = tim_q[{sel_chan, sel_dev}];
  assign sel_setup  = setup_q[sidx];

endmodule

// File: rtl/ata_pio_phase_seq.sv
module ata_pio_phase_seq
  import ata_pio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] setup_len,
  input  logic [LEN_W-1:0] act_len,
  input  logic [LEN_W-1:0] rec_len,
  output pio_phase_e       phase,
  output logic             accept,
  output logic             last_active,
  output logic             done
);
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] act_q, rec_q;
  logic             cnt_zero;

  assign cnt_zero    = (cnt == '0);
  assign accept      = (phase == PH_IDLE) && start;
  assign last_active = (phase == PH_ACTIVE) && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      act_q <= '0;
      rec_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_SETUP;
          cnt   <= setup_len - LEN_W'(1);
          act_q <= act_len;
          rec_q <= rec_len;
        end
        PH_SETUP: if (cnt_zero) begin
          phase <= PH_ACTIVE;
          cnt   <= act_q - LEN_W'(1);
        end else cnt <= cnt - LEN_W'(1);
        PH_ACTIVE: if (cnt_zero) begin
          phase <= PH_RECOV;
          cnt   <= rec_q - LEN_W'(1);
        end else cnt <= cnt - LEN_W'(1);
        PH_RECOV: if (cnt_zero) begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end else cnt <= cnt - LEN_W'(1);
      endcase
    end
  end

  // R9
  setup_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETUP && $past(phase) != PH_SETUP) |-> $past(phase) == PH_IDLE);

  // R5
  act_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ACTIVE && $past(phase) != PH_ACTIVE) |-> $past(phase) == PH_SETUP);

  // R6
  done_after_recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(phase) == PH_RECOV);

endmodule

// File: rtl/ata_pio_data_path.sv
module ata_pio_data_path
  import ata_pio_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              start_rw,
  input  logic [DATA_W-1:0] wdata,
  input  pio_phase_e        phase,
  input  logic              last_active,
  input  logic [DATA_W-1:0] dd_in,
  output logic              rw_q,
  output logic [DATA_W-1:0] dd_out,
  output logic              dd_oe,
  output logic [DATA_W-1:0] rdata
);
  logic rd_capture;

  assign rd_capture = last_active && !rw_q;
  assign dd_oe      = rw_q && (phase == PH_SETUP || phase == PH_ACTIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw_q   <= 1'b0;
      dd_out <= '0;
      rdata  <= '0;
    end else begin
      if (accept) begin
        rw_q   <= start_rw;
        dd_out <= wdata;
      end
      if (rd_capture) rdata <= dd_in;
    end
  end

  // R8
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dd_oe && $past(dd_oe)) |-> $stable(dd_out));

  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_capture) |-> $stable(rdata));

endmodule

// File: rtl/ata_pio_strobe_gen.sv
module ata_pio_strobe_gen
  import ata_pio_pkg::*;
#(
  parameter int CHAN_W = 1,
  parameter int DEV_W  = 1,
  parameter int CFG_AW = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              start,
  input  logic              start_rw,
  input  logic [CHAN_W-1:0] start_chan,
  input  logic [DEV_W-1:0]  start_dev,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] dd_in,
  output logic              busy,
  output logic              addr_valid,
  output logic              rd_stb_n,
  output logic              wr_stb_n,
  output logic [DATA_W-1:0] dd_out,
  output logic              dd_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  logic [7:0]       slot_timing;
  logic [1:0]       slot_setup;
  logic [LEN_W-1:0] setup_len, act_len, rec_len;
  pio_phase_e       phase;
  logic             accept, last_active, rw_q;

  ata_pio_timing_regs #(.CHAN_W(CHAN_W), .DEV_W(DEV_W), .CFG_AW(CFG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sel_chan(start_chan), .sel_dev(start_dev),
    .sel_timing(slot_timing), .sel_setup(slot_setup)
  );

  assign setup_len = setup_clocks(slot_setup);
  assign act_len   = act_clocks(slot_timing[7:4]);
  assign rec_len   = rec_clocks(slot_timing[3:0]);

  ata_pio_phase_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .setup_len(setup_len),
    .act_len(act_len), .rec_len(rec_len), .phase(phase), .accept(accept),
    .last_active(last_active), .done(done)
  );

  ata_pio_data_path #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .accept(accept), .start_rw(start_rw),
    .wdata(wdata), .phase(phase), .last_active(last_active), .dd_in(dd_in),
    .rw_q(rw_q), .dd_out(dd_out), .dd_oe(dd_oe), .rdata(rdata)
  );

  assign busy       = (phase != PH_IDLE);
  assign addr_valid = (phase != PH_IDLE);
  assign rd_stb_n   = !((phase == PH_ACTIVE) && !rw_q);
  assign wr_stb_n   = !((phase == PH_ACTIVE) && rw_q);

  // R5
  stb_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~rd_stb_n, ~wr_stb_n}));

  // R5
  stb_needs_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb_n || !wr_stb_n) |-> addr_valid);

  // R6
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/tb_ata_pio_strobe_gen.sv
module tb_ata_pio_strobe_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic start = 1'b0, start_rw = 1'b0;
  logic [0:0] start_chan = '0, start_dev = '0;
  logic [15:0] wdata = '0, dd_in = '0;
  logic busy, addr_valid, rd_stb_n, wr_stb_n, dd_oe, done;
  logic [15:0] dd_out, rdata;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] m_byte [4];
  logic [1:0] m_setup [3];
  logic [15:0] exp_rdata = '0;

  always #5 clk = ~clk;

  ata_pio_strobe_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start(start), .start_rw(start_rw),
    .start_chan(start_chan), .start_dev(start_dev), .wdata(wdata),
    .dd_in(dd_in), .busy(busy), .addr_valid(addr_valid), .rd_stb_n(rd_stb_n),
    .wr_stb_n(wr_stb_n), .dd_out(dd_out), .dd_oe(dd_oe), .rdata(rdata), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int m_setup_len(input logic [1:0] c);
    case (c)
      2'd0: return 4;
      2'd1: return 2;
      2'd2: return 3;
      default: return 5;
    endcase
  endfunction

  function automatic int m_act_len(input logic [3:0] n);
    return (n == 0) ? 16 : int'(n);
  endfunction

  function automatic int m_rec_len(input logic [3:0] n);
    if (n == 15) return 1;
    if (n == 0) return 16;
    return int'(n) + 1;
  endfunction

  function automatic int m_sidx(input int ch, input int dv);
    return (ch == 0) ? dv : 2;
  endfunction

  task automatic cfg_write(input int a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 4) m_byte[a] = d;
    else if (a < 7) m_setup[a-4] = d[7:6];
  endtask

  // mode 0: plain, 1: extra start while busy, 2: timing byte write mid-cycle
  task automatic run_cycle(input bit rw, input int ch, input int dv,
                           input logic [15:0] wd, input int mode, input logic [7:0] newb);
    int es, ea, er, ns, na, nr, k;
    bit seen_act, seen_done, sig_bad, oe_bad, wd_bad, kind_bad;
    logic [15:0] last_in;
    string stag;
    es = m_setup_len(m_setup[m_sidx(ch, dv)]);
    ea = m_act_len(m_byte[ch*2+dv][7:4]);
    er = m_rec_len(m_byte[ch*2+dv][3:0]);
    ns = 0; na = 0; nr = 0; k = 0;
    seen_act = 0; seen_done = 0; sig_bad = 0; oe_bad = 0; wd_bad = 0; kind_bad = 0;
    last_in = exp_rdata;
    @(negedge clk);
    start = 1'b1; start_rw = rw; start_chan = 1'(ch); start_dev = 1'(dv); wdata = wd;
    @(negedge clk);
    start = 1'b0; wdata = ~wd;
    while (k < 100) begin
      if (done) begin
        seen_done = 1;
        break;
      end
      if (!busy || !addr_valid) sig_bad = 1;
      if (!rd_stb_n || !wr_stb_n) begin
        na++; seen_act = 1;
        if (rw ? (wr_stb_n || !rd_stb_n) : (rd_stb_n || !wr_stb_n)) kind_bad = 1;
        if (dd_oe !== rw) oe_bad = 1;
        dd_in = 16'($urandom);
        last_in = dd_in;
      end else if (!seen_act) begin
        ns++;
        if (dd_oe !== rw) oe_bad = 1;
      end else begin
        nr++;
        if (dd_oe !== 1'b0) oe_bad = 1;
      end
      if (rw && dd_oe && dd_out !== wd) wd_bad = 1;
      if (k == 2 && mode == 1) begin
        start = 1'b1; start_rw = ~rw; start_chan = ~start_chan; wdata = 16'hDEAD;
      end
      if (k == 2 && mode == 2) begin
        cfg_we = 1'b1; cfg_addr = 3'(ch*2+dv); cfg_wdata = newb;
      end
      if (k == 3) begin
        start = 1'b0; cfg_we = 1'b0;
      end
      k++;
      @(negedge clk);
    end
    if (mode == 2) m_byte[ch*2+dv] = newb;
    chk(seen_done, "R6 done seen", int'(seen_done), 1);
    chk(!busy, "R6 busy low at done", int'(busy), 0);
    chk(!sig_bad, "R5 addr_valid/busy during cycle", int'(sig_bad), 0);
    chk(ns == es, (ch != 0) ? "R11 setup length" : "R2 setup length", ns, es);
    chk(na == ea, "R3 active length", na, ea);
    chk(nr == er, "R4 recovery length", nr, er);
    chk(!kind_bad, "R5 strobe direction", int'(kind_bad), 0);
    chk(!oe_bad, "R8 dd_oe window", int'(oe_bad), 0);
    chk(!wd_bad, "R8 write data hold", int'(wd_bad), 0);
    if (!rw) exp_rdata = last_in;
    chk(rdata === exp_rdata, "R7 read capture", int'(rdata), int'(exp_rdata));
    if (mode == 2) chk(na == ea && nr == er, "R10 timing latched at start", na*100+nr, ea*100+er);
    @(negedge clk);
    chk(!done && !busy, (mode == 1) ? "R9 no cycle from ignored start" : "R6 single done",
        int'({done, busy}), 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_byte[i] = 8'h00;
    for (int i = 0; i < 3; i++) m_setup[i] = 2'b11;
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(!busy && !addr_valid && !done && !dd_oe && rd_stb_n && wr_stb_n,
        "R1 in reset", int'({busy, addr_valid, done, dd_oe, rd_stb_n, wr_stb_n}), 3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !addr_valid && !done && !dd_oe && rd_stb_n && wr_stb_n,
        "R1 after reset", int'({busy, addr_valid, done, dd_oe, rd_stb_n, wr_stb_n}), 3);

    // R2: all setup codes, junk in the low bits
    for (int c = 0; c < 4; c++) begin
      cfg_write(4, {2'(c), 6'($urandom)});
      run_cycle(1'b0, 0, 0, 16'h1234, 0, 8'h00);
    end
    cfg_write(5, 8'h9F);
    run_cycle(1'b1, 0, 1, 16'hA5A5, 0, 8'h00);

    // R3 / R4 nibble corners
    cfg_write(0, 8'h0F); run_cycle(1'b0, 0, 0, 16'h0001, 0, 8'h00);
    cfg_write(0, 8'h10); run_cycle(1'b1, 0, 0, 16'h0002, 0, 8'h00);
    cfg_write(0, 8'hFE); run_cycle(1'b0, 0, 0, 16'h0003, 0, 8'h00);
    cfg_write(0, 8'h21); run_cycle(1'b1, 0, 0, 16'h0004, 0, 8'h00);

    // R11 shared setup on channel 1
    cfg_write(6, 8'h40 | 8'h2A);
    cfg_write(2, 8'h32); cfg_write(3, 8'h23);
    run_cycle(1'b0, 1, 0, 16'h5555, 0, 8'h00);
    run_cycle(1'b1, 1, 1, 16'hAAAA, 0, 8'h00);
    cfg_write(4, 8'hC0); cfg_write(5, 8'h00);
    run_cycle(1'b0, 1, 1, 16'h7777, 0, 8'h00);

    // R9 start while busy, R10 timing write mid-cycle
    run_cycle(1'b0, 0, 1, 16'h1111, 1, 8'h00);
    run_cycle(1'b1, 1, 0, 16'h2222, 1, 8'h00);
    run_cycle(1'b0, 0, 0, 16'h3333, 2, 8'h5B);
    run_cycle(1'b0, 0, 0, 16'h4444, 0, 8'h00);

    // R7 rdata held through a write
    run_cycle(1'b1, 0, 0, 16'h9999, 0, 8'h00);

    for (int it = 0; it < 120; it++) begin
      if ($urandom % 4 == 0) cfg_write(int'($urandom % 7), 8'($urandom));
      else run_cycle(1'($urandom), int'($urandom % 2), int'($urandom % 2),
                     16'($urandom), int'($urandom % 3), 8'($urandom));
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(1'b0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule